// File: doc/BRIEF.md
# Memory-Mapped Halfword Register Bank

This block is a bus slave that keeps thirty general 16-bit registers and one interrupt flag behind a word-addressed port. A bus master selects the block with a select strobe, names a location with a 5-bit word address (one step per 16-bit word, not per byte), and either reads or writes. Writes can be narrowed to single bytes with a two-bit byte-enable, where lane 0 is the low byte.

The two highest addresses control the interrupt line instead of holding data. A write to the top address raises the interrupt, and a write to the next one lowers it. Software raises the line as a doorbell, and the interrupt handler lowers it. A build-time parameter sets the access timing to either zero or one wait state. With zero wait states, read data is produced combinationally from the address. With one wait state, every transfer is two cycles long and the read path is registered.

Top module: `hw_regbank`

## Requirements
- R1: While `rst_n` is low at a rising edge, all thirty registers, `irq` and the registered read data are cleared to zero. Reset is synchronous.
- R2: With `WAIT_STATES`=0, a read returns the addressed value in the same cycle as the request. The master samples `rdata` at the edge that ends that cycle.
- R3: With `WAIT_STATES`=1, the master holds a read request for two cycles. `rdata` is loaded at the first edge and is valid when the master samples it at the second edge.
- R4: With `WAIT_STATES`=0, a write takes effect at the edge that ends its single cycle. With `WAIT_STATES`=1, it takes effect at the edge that ends the second of its two cycles.
- R5: `byte_en` bit 0 enables data bits 7..0 and bit 1 enables data bits 15..8. Bytes whose enable is low keep their old value. A write with `byte_en`=0 changes nothing.
- R6: When `sel` is low, the read and write strobes are ignored and no state changes.
- R7: A cycle with both `rd_en` and `wr_en` high is treated as a read. It returns the stored value and writes nothing.
- R8: A write to address 31 with `byte_en` bit 0 set drives `irq` high.
- R9: A write to address 30 with `byte_en` bit 0 set and `wdata` bit 0 equal to 1 drives `irq` low. If `wdata` bit 0 is 0, `irq` is unchanged.
- R10: A read of address 30 or 31 returns `irq` in bit 0 and zeros in bits 15..1. Reads never change `irq` or any register.
- R11: Addresses 0 to 29 are thirty independent storage words. A write to one of them leaves all the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 1 | Block is addressed in this cycle |
| addr | input | 5 | Word address |
| rd_en | input | 1 | Read request (slave to bus) |
| wr_en | input | 1 | Write request (bus to slave) |
| byte_en | input | 2 | Per-byte write enable, bit 0 = low byte |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the one-wait-state timing. From outside, a correct design looks the same as one that commits or samples one edge early, unless the master holds each request for exactly two cycles and samples at the second edge. For this reason, the bench drives two instances, one per timing setting, through a bus model that holds each transfer for the configured number of cycles and samples read data only at the final edge. Read-after-write sequences then expose any edge misplacement. Byte-lane masking and the interrupt set/clear pair are reached with directed writes. Seeded random traffic then mixes lanes, addresses and the interrupt locations against a bench model.

// File: rtl/hw_regbank_pkg.sv
// Package: shared constants and types for the halfword register bank.
// Assumes byte lanes of eight bits.
package hw_regbank_pkg;
    localparam int unsigned BYTE_W = 8;

    // Phase of a one-wait-state transfer.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } rb_phase_e;
endpackage

// File: rtl/rb_access_seq.sv
// Access sequencer: turns bus strobes into a write-commit pulse and a
// read-capture strobe. It assumes the master holds its request for
// WAIT_STATES+1 cycles. A cycle with both strobes high counts as a read.
module rb_access_seq
    import hw_regbank_pkg::*;
#(
    parameter int unsigned WAIT_STATES = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic rd_en,
    input  logic wr_en,
    output logic commit,
    output logic cap_rd
);
    generate
        if (WAIT_STATES == 0) begin : g_ws0
            // Zero wait: a write commits at the end of its only cycle.
            assign commit = sel & wr_en & ~rd_en;
            assign cap_rd = sel & rd_en;
        end else begin : g_ws1
            rb_phase_e phase;

            // Phase tracking: the first cycle of a transfer moves to WAIT.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    phase <= PH_IDLE;
                else if (phase == PH_IDLE && sel && (rd_en || wr_en))
                    phase <= PH_WAIT;
                else
                    phase <= PH_IDLE;
            end

            assign commit = (phase == PH_WAIT) & sel & wr_en & ~rd_en;
            assign cap_rd = (phase == PH_IDLE) & sel & rd_en;

            // R4: a commit follows a first cycle that carried the same write.
            p_commit_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
                commit |-> $past(sel && wr_en && !rd_en));
        end
    endgenerate

    // R6, R7: a commit only happens in a selected cycle that is a pure write.
    p_commit_needs_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (sel && wr_en && !rd_en));
endmodule

// File: rtl/rb_store.sv
// Storage words: NUM_WORDS halfwords with per-byte masked writes and a
// combinational read port. Addresses at or above NUM_WORDS read as zero here.
module rb_store
    import hw_regbank_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned NUM_WORDS = 30
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W/BYTE_W-1:0]   byte_en,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          word_out
);
    localparam int unsigned LANES = DATA_W / BYTE_W;

    logic [DATA_W-1:0] mem [NUM_WORDS];
    logic [DATA_W-1:0] wmask;
    logic              in_range;
    logic              we;

    // Expand each lane enable into a bit mask.
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign wmask[l*BYTE_W +: BYTE_W] = {BYTE_W{byte_en[l]}};
        end
    endgenerate

    assign in_range = (addr < ADDR_W'(NUM_WORDS));
    assign we       = commit & in_range;

    // Storage update: clear on reset, masked merge on a committed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= (mem[addr] & ~wmask) | (wdata & wmask);
        end
    end

    // Read selection for in-range addresses.
    always_comb begin
        word_out = '0;
        if (in_range) word_out = mem[addr];
    end

    // R5: bits whose lane is disabled keep their previous value.
    p_lane_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mem[$past(addr)] & ~$past(wmask)) ==
                ($past(mem[addr]) & ~$past(wmask))));
endmodule

// File: rtl/rb_irq_ctrl.sv
// Interrupt flag: set by a low-lane write to SET_ADDR, cleared by a low-lane
// write with data bit 0 high to CLR_ADDR. It assumes commit marks only real writes.
module rb_irq_ctrl #(
    parameter int unsigned ADDR_W   = 5,
    parameter int unsigned SET_ADDR = 31,
    parameter int unsigned CLR_ADDR = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lane0_en,
    input  logic              data_b0,
    output logic              irq
);
    logic hit_set;
    logic hit_clr;

    assign hit_set = commit & lane0_en & (addr == ADDR_W'(SET_ADDR));
    assign hit_clr = commit & lane0_en & data_b0 & (addr == ADDR_W'(CLR_ADDR));

    // Flag update: set has its own address, clear needs data bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (hit_set)
            irq <= 1'b1;
        else if (hit_clr)
            irq <= 1'b0;
    end

    // R8: a qualifying write to the set location raises the line.
    p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && lane0_en && addr == ADDR_W'(SET_ADDR)) |=> irq);
    // R9: a qualifying write to the clear location lowers the line.
    p_irq_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && lane0_en && data_b0 && addr == ADDR_W'(CLR_ADDR)) |=> !irq);
    // R10: with no commit the flag holds.
    p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(irq));
endmodule

// File: rtl/hw_regbank.sv
// Top: halfword register bank slave. The storage words sit below the two
// interrupt-control locations. WAIT_STATES picks a combinational (0) or a
// registered (1) read path. It assumes a master that holds each transfer for
// WAIT_STATES+1 cycles and samples at the final edge.
module hw_regbank
    import hw_regbank_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned WAIT_STATES = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     rd_en,
    input  logic                     wr_en,
    input  logic [DATA_W/8-1:0]      byte_en,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic                     irq
);
    localparam int unsigned NUM_WORDS = (2 ** ADDR_W) - 2;
    localparam int unsigned SET_ADDR  = (2 ** ADDR_W) - 1;
    localparam int unsigned CLR_ADDR  = (2 ** ADDR_W) - 2;

    logic              commit;
    logic              cap_rd;
    logic [DATA_W-1:0] word_out;
    logic [DATA_W-1:0] rd_comb;

    rb_access_seq #(.WAIT_STATES(WAIT_STATES)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .rd_en  (rd_en),
        .wr_en  (wr_en),
        .commit (commit),
        .cap_rd (cap_rd)
    );

    rb_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .addr     (addr),
        .byte_en  (byte_en),
        .wdata    (wdata),
        .word_out (word_out)
    );

    rb_irq_ctrl #(.ADDR_W(ADDR_W), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .addr     (addr),
        .lane0_en (byte_en[0]),
        .data_b0  (wdata[0]),
        .irq      (irq)
    );

    // Read source: a storage word, or the status word at the control locations.
    always_comb begin
        if (addr < ADDR_W'(NUM_WORDS))
            rd_comb = word_out;
        else
            rd_comb = {{(DATA_W-1){1'b0}}, irq};
    end

    generate
        if (WAIT_STATES == 0) begin : g_rd_comb
            assign rdata = rd_comb;
        end else begin : g_rd_reg
            // Registered read: loaded on the first cycle of a read transfer.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rdata <= '0;
                else if (cap_rd)
                    rdata <= rd_comb;
            end
        end
    endgenerate

    // R10: a read cycle without a commit leaves the interrupt line alone.
    p_read_no_side_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_rd && !commit) |=> (irq == $past(irq)));
endmodule

// File: tb/hw_regbank_bench.sv
// Bench: two instances (zero and one wait state) driven by a bus model that
// holds each request for WAIT_STATES+1 cycles and samples at the final edge.
module hw_regbank_bench;
    localparam int NW = 30;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  sel_v, rd_v, wr_v;
    logic [4:0]  ad_v [2];
    logic [1:0]  be_v [2];
    logic [15:0] wd_v [2];
    logic [15:0] rdq  [2];
    logic [1:0]  irq_v;

    logic [15:0] m_mem [2][NW];
    logic        m_irq [2];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [15:0] q;

    always #2 clk = ~clk;

    hw_regbank #(.WAIT_STATES(0)) u_hw_regbank (
        .clk(clk), .rst_n(rst_n), .sel(sel_v[0]), .addr(ad_v[0]),
        .rd_en(rd_v[0]), .wr_en(wr_v[0]), .byte_en(be_v[0]),
        .wdata(wd_v[0]), .rdata(rdq[0]), .irq(irq_v[0])
    );

    hw_regbank #(.WAIT_STATES(1)) u_hw_regbank_ws1 (
        .clk(clk), .rst_n(rst_n), .sel(sel_v[1]), .addr(ad_v[1]),
        .rd_en(rd_v[1]), .wr_en(wr_v[1]), .byte_en(be_v[1]),
        .wdata(wd_v[1]), .rdata(rdq[1]), .irq(irq_v[1])
    );

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] o, input logic [15:0] d,
                                          input logic [1:0] be);
        logic [15:0] m;
        m = {{8{be[1]}}, {8{be[0]}}};
        return (o & ~m) | (d & m);
    endfunction

    function automatic logic [15:0] exp_rd(input int w, input logic [4:0] a);
        if (a < 5'(NW)) return m_mem[w][a];
        return {15'b0, m_irq[w]};
    endfunction

    // Model update for an accepted write.
    task automatic model_wr(input int w, input logic [4:0] a, input logic [1:0] be,
                            input logic [15:0] d);
        if (a < 5'(NW)) m_mem[w][a] = merge(m_mem[w][a], d, be);
        else if (be[0]) begin
            if (a == 5'd31) m_irq[w] = 1'b1;
            else if (d[0]) m_irq[w] = 1'b0;
        end
    endtask

    // Bus transfer: held for w+1 cycles, read data sampled before the final edge.
    task automatic xfer(input int w, input logic s, input logic r, input logic wv,
                        input logic [4:0] a, input logic [1:0] be, input logic [15:0] d,
                        output logic [15:0] qo);
        @(negedge clk);
        sel_v[w] = s; rd_v[w] = r; wr_v[w] = wv;
        ad_v[w] = a; be_v[w] = be; wd_v[w] = d;
        qo = '0;
        for (int c = 0; c <= w; c++) begin
            if (c == w) begin
                #1;
                qo = rdq[w];
            end
            @(posedge clk);
            if (c < w) @(negedge clk);
        end
        @(negedge clk);
        sel_v[w] = 1'b0; rd_v[w] = 1'b0; wr_v[w] = 1'b0;
        if (s && wv && !r) model_wr(w, a, be, d);
    endtask

    task automatic do_wr(input int w, input logic [4:0] a, input logic [1:0] be,
                         input logic [15:0] d);
        logic [15:0] dummy;
        xfer(w, 1'b1, 1'b0, 1'b1, a, be, d, dummy);
    endtask

    task automatic do_rd(input int w, input logic [4:0] a, input string req);
        logic [15:0] got;
        xfer(w, 1'b1, 1'b1, 1'b0, a, 2'b00, 16'h0, got);
        chk(req, got, exp_rd(w, a));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        sel_v = '0; rd_v = '0; wr_v = '0;
        for (int w = 0; w < 2; w++) begin
            ad_v[w] = '0; be_v[w] = '0; wd_v[w] = '0; m_irq[w] = 1'b0;
            for (int i = 0; i < NW; i++) m_mem[w][i] = '0;
        end
        void'($urandom(32'd1729));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int w = 0; w < 2; w++) begin
            string rq;
            rq = (w == 0) ? "R2" : "R3";
            // R1: reset state at the ports.
            chk("R1 irq", {15'b0, irq_v[w]}, 16'h0);
            chk("R1 rdata", rdq[w], 16'h0);
            do_rd(w, 5'd0, "R1 word0");
            do_rd(w, 5'd29, "R1 word29");

            // R4 / R2 / R3: full write then read back.
            do_wr(w, 5'd3, 2'b11, 16'h1234);
            do_rd(w, 5'd3, (w == 0) ? "R4 R2 full" : "R4 R3 full");
            do_wr(w, 5'd4, 2'b11, 16'hBEEF);
            do_rd(w, 5'd3, {rq, " addr3 after addr4"});
            do_rd(w, 5'd4, {rq, " addr4"});

            // R5: byte lanes.
            do_wr(w, 5'd3, 2'b01, 16'hAACD);
            do_rd(w, 5'd3, "R5 low lane");
            do_wr(w, 5'd3, 2'b10, 16'h77EE);
            do_rd(w, 5'd3, "R5 high lane");
            do_wr(w, 5'd3, 2'b00, 16'hFFFF);
            do_rd(w, 5'd3, "R5 no lanes");

            // R6: strobes without select.
            xfer(w, 1'b0, 1'b0, 1'b1, 5'd3, 2'b11, 16'h0F0F, q);
            do_rd(w, 5'd3, "R6 unselected write");
            xfer(w, 1'b0, 1'b0, 1'b1, 5'd31, 2'b11, 16'h0001, q);
            chk("R6 unselected irq", {15'b0, irq_v[w]}, 16'h0);

            // R7: read and write together act as a read.
            xfer(w, 1'b1, 1'b1, 1'b1, 5'd4, 2'b11, 16'h5555, q);
            chk("R7 returns stored", q, 16'hBEEF);
            do_rd(w, 5'd4, "R7 no write");

            // R8 / R9 / R10: interrupt locations.
            do_wr(w, 5'd31, 2'b10, 16'h0001);
            chk("R8 high lane only", {15'b0, irq_v[w]}, 16'h0);
            do_wr(w, 5'd31, 2'b01, 16'h0000);
            chk("R8 set", {15'b0, irq_v[w]}, 16'h1);
            do_rd(w, 5'd31, "R10 status 31");
            do_rd(w, 5'd30, "R10 status 30");
            chk("R10 irq after read", {15'b0, irq_v[w]}, 16'h1);
            do_wr(w, 5'd30, 2'b11, 16'hFFFE);
            chk("R9 bit0 zero", {15'b0, irq_v[w]}, 16'h1);
            do_wr(w, 5'd30, 2'b01, 16'h0001);
            chk("R9 clear", {15'b0, irq_v[w]}, 16'h0);
            do_rd(w, 5'd31, "R10 status cleared");

            // R11: distinct words at the ends of the range.
            do_wr(w, 5'd0, 2'b11, 16'hA000);
            do_wr(w, 5'd29, 2'b11, 16'hB029);
            do_rd(w, 5'd0, "R11 word0");
            do_rd(w, 5'd29, "R11 word29");
            do_rd(w, 5'd28, "R11 word28 untouched");

            // Seeded random traffic against the model.
            for (int k = 0; k < 300; k++) begin
                logic [4:0]  a;
                logic [1:0]  be;
                logic [15:0] d;
                int          op;
                a  = 5'($urandom_range(0, 31));
                be = 2'($urandom_range(0, 3));
                d  = 16'($urandom);
                op = $urandom_range(0, 9);
                if (op < 5) begin
                    do_wr(w, a, be, d);
                    chk("R8 R9 random irq", {15'b0, irq_v[w]}, {15'b0, m_irq[w]});
                end else if (op < 9) begin
                    do_rd(w, a, "R11 R5 random read");
                end else begin
                    xfer(w, 1'b1, 1'b1, 1'b1, a, be, d, q);
                    chk("R7 random", q, exp_rd(w, a));
                end
            end
            for (int i = 0; i < NW; i++) do_rd(w, 5'(i), "R11 final sweep");

            // R1: reset in mid-life clears stored state again.
            @(negedge clk);
            rst_n = 1'b0;
            @(posedge clk);
            @(negedge clk);
            rst_n = 1'b1;
            for (int i = 0; i < NW; i++) m_mem[w][i] = '0;
            m_irq[w] = 1'b0;
            m_irq[1-w] = 1'b0;
            for (int i = 0; i < NW; i++) m_mem[1-w][i] = '0;
            chk("R1 irq after reset", {15'b0, irq_v[w]}, 16'h0);
            chk("R1 rdata after reset", rdq[w], 16'h0);
            do_rd(w, 5'd3, "R1 word3 after reset");
        end
        finish_run();
    end
endmodule